// File: doc/BRIEF.md
# Lossless Colour Tile Compressor

This block sits on the write path of a graphics pipeline. It takes one square tile of 32-bit colour pixels at a time, one pixel per cycle in raster order. It works out which of four lossless encodings gives the shortest result and streams that result out as 32-bit words. Each tile has a 2-bit encoding tag and its length in bytes alongside the payload. A consumer stores these with the tile so that a matching reader can rebuild the pixels exactly.

Three encodings are tried in a fixed order of preference. First comes one colour per aligned four-column by two-row region. Next comes one colour per aligned two-by-two region. Last comes a per-channel difference code in which each pixel is coded against a fixed neighbour and the channel fields are packed at the smallest signed width that holds every difference in the tile. When none of them applies, or the difference code would be too long, the tile is sent raw. While a tile streams in, the block builds the tests and the widths as it goes, so the encoding is known as soon as the last pixel arrives.

Top module: `tile_color_packer`

## Requirements
- R1: A tile is 64 pixels (8x8) accepted in raster order (index = row*8 + column) on cycles where in_valid and in_ready are both high; in_ready is low from the acceptance of pixel 63 until the cycle after the final output word is taken, and high again after that.
- R2: If every aligned region of 4 columns by 2 rows holds one colour, the tag is 1, the length is 32 bytes and the 8 payload words are the region colours in row-major region order (region k starts at pixel (k/2)*16 + (k%2)*4).
- R3: Otherwise, if every aligned 2x2 region holds one colour, the tag is 2, the length is 64 bytes and the 16 payload words are the region colours in row-major region order (region k starts at pixel (k/4)*16 + (k%4)*2).
- R4: In the difference code, word 0 is pixel 0 unchanged and bits 15:0 of word 1 hold four 4-bit width fields: red width in bits 3:0, green in 7:4, blue in 11:8, alpha in 15:12, where red is pixel bits 7:0, green 15:8, blue 23:16 and alpha 31:24.
- R5: A channel width is the largest, over pixels 1 to 63, of the width of that channel's 8-bit difference read as a signed value: 0 for a zero difference, otherwise the fewest two's-complement bits that hold it (1 for -1, 2 for +1, 8 at most).
- R6: A pixel in column 0 is differenced against the pixel above it and every other pixel against the pixel to its left, channel by channel modulo 256. For pixels 1 to 63 in order, the low width bits of the red, green, blue and alpha differences are appended least-significant-bit first into a continuous stream that begins at bit 16 of word 1, and the last word is padded with zeros.
- R7: The difference code is selected only when its length, 4*ceil((48 + 63*S)/32) bytes with S the sum of the four widths, is at most 128 bytes; its reported length is that value.
- R8: When no other encoding is selected, the tag is 0, the length is 256 bytes and the 64 payload words are the pixels in input order.
- R9: The tag encodes 0 = raw, 1 = 4x2 constant, 2 = 2x2 constant, 3 = difference code, and the tests apply in that priority: 4x2, then 2x2, then difference, then raw. Every tile is tested afresh, whatever the previous tile was.
- R10: A word is taken when out_valid and out_ready are both high. While out_valid is high and out_ready low, out_data stays unchanged. out_last is high only with the final word. out_mode and out_bytes hold their values for every word of a tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block accepts a pixel |
| in_data | input | 32 | Pixel, alpha/blue/green/red from high byte to low |
| out_valid | output | 1 | Payload word offered |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Payload word |
| out_last | output | 1 | Final word of the tile |
| out_mode | output | 2 | Encoding tag |
| out_bytes | output | 9 | Payload length in bytes |

## Verification
The bench uses five kinds of tile: 4x2-constant blocks, 2x2-constant blocks that break 4x2 constancy, a smooth gradient, and a pair of alternating-column tiles whose width sum is 15 in one and 16 in the other. A pseudo-random tile is the sixth. The constant tiles show whether the priority cascade and the region ordering are right. The gradient checks the neighbour rule, because its row-start differences differ from its in-row ones. The alternating pair sits on either side of the 128-byte limit and carries negative and positive differences of every width class, so it checks the width rule and the fallback to raw. The gradient is sent a second time under back-pressure to show that words are held while stalled.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  localparam int CH_BITS   = 8;
  localparam int CHANNELS  = 4;
  localparam int PIX_BITS  = CH_BITS * CHANNELS;
  localparam int WFIELD    = 4;
  localparam int HDR_BITS  = WFIELD * CHANNELS;

  localparam logic [1:0] TAG_RAW   = 2'd0;
  localparam logic [1:0] TAG_C42   = 2'd1;
  localparam logic [1:0] TAG_C22   = 2'd2;
  localparam logic [1:0] TAG_DELTA = 2'd3;

  // Signed bit width of one channel difference; zero needs no bits.
  function automatic logic [3:0] sdelta_width(input logic [CH_BITS-1:0] d);
    logic [CH_BITS-1:0] mag;
    logic [3:0] w;
    mag = d[CH_BITS-1] ? ~d : d;
    w   = 4'd1;
    for (int b = 0; b < CH_BITS - 1; b++)
      if (mag[b]) w = 4'(b + 2);
    if (d == '0) w = 4'd0;
    return w;
  endfunction

  // Per-channel wrap-around difference cur - ref.
  function automatic logic [PIX_BITS-1:0] channel_delta(input logic [PIX_BITS-1:0] cur,
                                                        input logic [PIX_BITS-1:0] ref_px);
    logic [PIX_BITS-1:0] r;
    for (int ch = 0; ch < CHANNELS; ch++)
      r[CH_BITS*ch +: CH_BITS] = cur[CH_BITS*ch +: CH_BITS] - ref_px[CH_BITS*ch +: CH_BITS];
    return r;
  endfunction

  // Concatenate channel fields, each cut to its width, lowest channel first.
  function automatic logic [PIX_BITS-1:0] pack_fields(input logic [PIX_BITS-1:0] d,
                                                      input logic [HDR_BITS-1:0] w);
    logic [PIX_BITS-1:0] r;
    int pos;
    r   = '0;
    pos = 0;
    for (int ch = 0; ch < CHANNELS; ch++) begin
      int wc;
      logic [PIX_BITS-1:0] f;
      wc  = int'(w[WFIELD*ch +: WFIELD]);
      f   = {{(PIX_BITS-CH_BITS){1'b0}}, d[CH_BITS*ch +: CH_BITS]} &
            ((PIX_BITS'(1) << wc) - PIX_BITS'(1));
      r   = r | (f << pos);
      pos = pos + wc;
    end
    return r;
  endfunction

  // First pixel of the aligned region holding pixel idx.
  function automatic int region_base(input int idx, input int side_log2,
                                     input int rw_log2, input int rh_log2);
    int row, col;
    row = (idx >> side_log2) & ~((1 << rh_log2) - 1);
    col = (idx & ((1 << side_log2) - 1)) & ~((1 << rw_log2) - 1);
    return (row << side_log2) | col;
  endfunction

  // First pixel of region number k in row-major region order.
  function automatic int region_start(input int k, input int side_log2,
                                      input int rw_log2, input int rh_log2);
    int per_row_log2, row, col;
    per_row_log2 = side_log2 - rw_log2;
    row = k >> per_row_log2;
    col = k & ((1 << per_row_log2) - 1);
    return ((row << rh_log2) << side_log2) | (col << rw_log2);
  endfunction

endpackage

// File: rtl/tcp_analyzer.sv
module tcp_analyzer #(
  parameter int SIDE_LOG2 = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [2*SIDE_LOG2-1:0]        idx,
  input  logic [tcp_pkg::PIX_BITS-1:0]  pix,
  input  logic [tcp_pkg::PIX_BITS-1:0]  base42_pix,
  input  logic [tcp_pkg::PIX_BITS-1:0]  base22_pix,
  input  logic [tcp_pkg::PIX_BITS-1:0]  nbr_pix,
  output logic                          all_c42,
  output logic                          all_c22,
  output logic [tcp_pkg::HDR_BITS-1:0]  widths,
  output logic [5:0]                    width_sum
);
  import tcp_pkg::*;

  logic first_px;
  logic hit42, hit22;
  logic [PIX_BITS-1:0] dlt;
  logic [3:0] wmax [CHANNELS];

  assign first_px = (idx == '0);
  assign hit42    = (pix == base42_pix);
  assign hit22    = (pix == base22_pix);
  assign dlt      = channel_delta(pix, nbr_pix);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      all_c42 <= 1'b0;
      all_c22 <= 1'b0;
    end else if (take) begin
      all_c42 <= (first_px || all_c42) && hit42;
      all_c22 <= (first_px || all_c22) && hit22;
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic [3:0] w_now;
    assign w_now = first_px ? 4'd0 : sdelta_width(dlt[CH_BITS*ch +: CH_BITS]);

    always_ff @(posedge clk) begin
      if (!rst_n)       wmax[ch] <= 4'd0;
      else if (take)    wmax[ch] <= (first_px || (w_now > wmax[ch])) ? w_now : wmax[ch];
    end

    assign widths[WFIELD*ch +: WFIELD] = wmax[ch];

    AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wmax[ch] <= 4'(CH_BITS)); // R5
  end

  assign width_sum = 6'(wmax[0]) + 6'(wmax[1]) + 6'(wmax[2]) + 6'(wmax[3]);

  AST_C42_IMPLIES_C22: assert property (@(posedge clk) disable iff (!rst_n)
    all_c42 |-> all_c22); // R9

endmodule

// File: rtl/tcp_packer.sv
module tcp_packer #(
  parameter int SIDE_LOG2 = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    mode,
  input  logic [tcp_pkg::HDR_BITS-1:0]  widths,
  input  logic [5:0]                    width_sum,
  input  logic [2*SIDE_LOG2:0]          total_words,
  output logic [2*SIDE_LOG2-1:0]        rd_a_idx,
  input  logic [tcp_pkg::PIX_BITS-1:0]  rd_a,
  output logic [2*SIDE_LOG2-1:0]        rd_b_idx,
  input  logic [tcp_pkg::PIX_BITS-1:0]  rd_b,
  input  logic                          out_ready,
  output logic                          out_valid,
  output logic [tcp_pkg::PIX_BITS-1:0]  out_data,
  output logic                          out_last,
  output logic                          done
);
  import tcp_pkg::*;

  localparam int SIDE   = 1 << SIDE_LOG2;
  localparam int PIX    = SIDE * SIDE;
  localparam int IDX_W  = 2 * SIDE_LOG2;
  localparam int WORD_W = IDX_W + 1;
  localparam int ACC_W  = 2 * PIX_BITS;
  localparam int FILL_W = $clog2(ACC_W) + 1;

  logic              active;
  logic [WORD_W-1:0] widx;
  logic [WORD_W-1:0] pidx;
  logic [ACC_W-1:0]  acc;
  logic [FILL_W-1:0] fill;

  logic is_delta, fire, last_w, append, tail_ready;
  logic [IDX_W-1:0] word_idx;
  logic [PIX_BITS-1:0] packed_px;

  assign is_delta   = (mode == TAG_DELTA);
  assign last_w     = (widx == total_words - WORD_W'(1));
  assign tail_ready = (pidx == WORD_W'(PIX)) && (fill != '0);

  always_comb begin
    unique case (mode)
      TAG_C42: word_idx = IDX_W'(region_start(int'(widx), SIDE_LOG2, 2, 1));
      TAG_C22: word_idx = IDX_W'(region_start(int'(widx), SIDE_LOG2, 1, 1));
      default: word_idx = IDX_W'(widx);
    endcase
  end

  assign rd_a_idx  = (is_delta && widx != '0) ? IDX_W'(pidx) : word_idx;
  assign rd_b_idx  = (rd_a_idx[SIDE_LOG2-1:0] == '0) ? rd_a_idx - IDX_W'(SIDE)
                                                      : rd_a_idx - IDX_W'(1);
  assign packed_px = pack_fields(channel_delta(rd_a, rd_b), widths);

  always_comb begin
    if (!is_delta)       out_valid = active;
    else if (widx == '0) out_valid = active;
    else                 out_valid = active && ((fill >= FILL_W'(PIX_BITS)) || tail_ready);
  end

  assign out_data = (is_delta && widx != '0) ? acc[PIX_BITS-1:0] : rd_a;
  assign fire     = out_valid && out_ready;
  assign out_last = out_valid && last_w;
  assign done     = fire && last_w;
  assign append   = active && is_delta && (widx != '0) &&
                    (fill < FILL_W'(PIX_BITS)) && (pidx < WORD_W'(PIX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      widx   <= '0;
      pidx   <= '0;
      acc    <= '0;
      fill   <= '0;
    end else if (start) begin
      active <= 1'b1;
      widx   <= '0;
      pidx   <= WORD_W'(1);
      acc    <= '0;
      fill   <= '0;
    end else if (active) begin
      if (fire) begin
        widx <= widx + WORD_W'(1);
        if (last_w) active <= 1'b0;
        if (is_delta) begin
          if (widx == '0) begin
            acc  <= ACC_W'(widths);
            fill <= FILL_W'(HDR_BITS);
          end else begin
            acc  <= acc >> PIX_BITS;
            fill <= (fill >= FILL_W'(PIX_BITS)) ? fill - FILL_W'(PIX_BITS) : '0;
          end
        end
      end else if (append) begin
        acc  <= acc | (ACC_W'(packed_px) << fill);
        fill <= fill + FILL_W'(width_sum);
        pidx <= pidx + WORD_W'(1);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    active && is_delta |-> fill < FILL_W'(ACC_W)); // R6

  AST_WORD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> widx < total_words); // R10

endmodule

// File: rtl/tile_color_packer.sv
module tile_color_packer #(
  parameter int SIDE_LOG2       = 3,
  parameter int MAX_DELTA_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic [1:0]  out_mode,
  output logic [8:0]  out_bytes
);
  import tcp_pkg::*;

  localparam int SIDE   = 1 << SIDE_LOG2;
  localparam int PIX    = SIDE * SIDE;
  localparam int IDX_W  = 2 * SIDE_LOG2;
  localparam int WORD_W = IDX_W + 1;
  localparam int BYTE_W = WORD_W + 2;

  typedef enum logic {ST_LOAD, ST_EMIT} state_e;

  state_e           state;
  logic [IDX_W-1:0] cnt;
  logic [PIX_BITS-1:0] tile_q [PIX];

  logic accept, last_in, pk_done;
  logic [IDX_W-1:0] b42_idx, b22_idx, nbr_idx, rd_a_idx, rd_b_idx;
  logic [PIX_BITS-1:0] b42_pix, b22_pix, nbr_pix;
  logic all_c42, all_c22;
  logic [HDR_BITS-1:0] widths;
  logic [5:0] width_sum;
  logic [WORD_W-1:0] total_words;
  logic [BYTE_W-1:0] delta_bytes;
  logic delta_fits;
  int   delta_bits;

  assign in_ready = (state == ST_LOAD);
  assign accept   = in_valid && in_ready;
  assign last_in  = accept && (cnt == IDX_W'(PIX - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_LOAD;
      cnt   <= '0;
    end else begin
      if (accept) cnt <= cnt + IDX_W'(1);
      if (last_in)      state <= ST_EMIT;
      else if (pk_done) state <= ST_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) tile_q[cnt] <= in_data;
  end

  // Region bases and neighbour of the incoming pixel; a base equal to the
  // current index is the incoming pixel itself.
  assign b42_idx = IDX_W'(region_base(int'(cnt), SIDE_LOG2, 2, 1));
  assign b22_idx = IDX_W'(region_base(int'(cnt), SIDE_LOG2, 1, 1));
  assign nbr_idx = (cnt[SIDE_LOG2-1:0] == '0) ? cnt - IDX_W'(SIDE) : cnt - IDX_W'(1);
  assign b42_pix = (b42_idx == cnt) ? in_data : tile_q[b42_idx];
  assign b22_pix = (b22_idx == cnt) ? in_data : tile_q[b22_idx];
  assign nbr_pix = tile_q[nbr_idx];

  tcp_analyzer #(.SIDE_LOG2(SIDE_LOG2)) u_analyzer (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (accept),
    .idx        (cnt),
    .pix        (in_data),
    .base42_pix (b42_pix),
    .base22_pix (b22_pix),
    .nbr_pix    (nbr_pix),
    .all_c42    (all_c42),
    .all_c22    (all_c22),
    .widths     (widths),
    .width_sum  (width_sum)
  );

  always_comb begin
    delta_bits  = PIX_BITS + HDR_BITS + (PIX - 1) * int'(width_sum);
    delta_bytes = BYTE_W'(((delta_bits + PIX_BITS - 1) / PIX_BITS) * 4);
    delta_fits  = (delta_bytes <= BYTE_W'(MAX_DELTA_BYTES));
    if (all_c42) begin
      out_mode    = TAG_C42;
      total_words = WORD_W'(PIX / 8);
    end else if (all_c22) begin
      out_mode    = TAG_C22;
      total_words = WORD_W'(PIX / 4);
    end else if (delta_fits) begin
      out_mode    = TAG_DELTA;
      total_words = WORD_W'(delta_bytes >> 2);
    end else begin
      out_mode    = TAG_RAW;
      total_words = WORD_W'(PIX);
    end
  end

  assign out_bytes = 9'({total_words, 2'b00});

  tcp_packer #(.SIDE_LOG2(SIDE_LOG2)) u_packer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (last_in),
    .mode        (out_mode),
    .widths      (widths),
    .width_sum   (width_sum),
    .total_words (total_words),
    .rd_a_idx    (rd_a_idx),
    .rd_a        (tile_q[rd_a_idx]),
    .rd_b_idx    (rd_b_idx),
    .rd_b        (tile_q[rd_b_idx]),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .done        (pk_done)
  );

  AST_NO_INPUT_DURING_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R1

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready); // R1

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mode)); // R10

  AST_DELTA_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_mode == TAG_DELTA |-> out_bytes <= 9'(MAX_DELTA_BYTES)); // R7

endmodule

// File: tb/sim_tile_color_packer.sv
module sim_tile_color_packer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_last;
  logic [1:0]  out_mode;
  logic [8:0]  out_bytes;

  always #10 clk = ~clk;

  tile_color_packer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_mode(out_mode),
    .out_bytes(out_bytes)
  );

  int checks = 0;
  int failures = 0;

  logic [31:0] tile  [64];
  logic [31:0] exp_w [80];
  logic [31:0] got_w [80];
  int exp_n, exp_mode, exp_bytes, exp_hdr;
  int got_n, got_mode, got_bytes;
  bit hold_err, rdy_err, const_err;
  logic sb [0:2559];
  int sp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // Smallest signed width of a difference in -128..127, 0 for zero.
  function automatic int bw(input int d);
    if (d == 0) return 0;
    for (int w = 1; w <= 8; w++)
      if (d >= -(1 << (w - 1)) && d < (1 << (w - 1))) return w;
    return 8;
  endfunction

  task automatic put_bits(input logic [31:0] v, input int w);
    for (int j = 0; j < w; j++) begin
      sb[sp] = v[j];
      sp++;
    end
  endtask

  task automatic model();
    bit c42, c22;
    int wm [4];
    int s, bits, words;
    c42 = 1; c22 = 1;
    for (int i = 0; i < 64; i++) begin
      int r, c;
      r = i / 8; c = i % 8;
      if (tile[i] != tile[(r / 2) * 16 + (c / 4) * 4]) c42 = 0;
      if (tile[i] != tile[(r / 2) * 16 + (c / 2) * 2]) c22 = 0;
    end
    for (int ch = 0; ch < 4; ch++) wm[ch] = 0;
    for (int i = 1; i < 64; i++) begin
      int nb;
      nb = (i % 8 == 0) ? i - 8 : i - 1;
      for (int ch = 0; ch < 4; ch++) begin
        logic [7:0] df;
        int dd;
        df = tile[i][8*ch +: 8] - tile[nb][8*ch +: 8];
        dd = $signed(df);
        if (bw(dd) > wm[ch]) wm[ch] = bw(dd);
      end
    end
    s = wm[0] + wm[1] + wm[2] + wm[3];
    bits = 48 + 63 * s;
    words = (bits + 31) / 32;
    exp_hdr = wm[0] | (wm[1] << 4) | (wm[2] << 8) | (wm[3] << 12);
    if (c42) begin
      exp_mode = 1; exp_n = 8;
      for (int k = 0; k < 8; k++) exp_w[k] = tile[(k / 2) * 16 + (k % 2) * 4];
    end else if (c22) begin
      exp_mode = 2; exp_n = 16;
      for (int k = 0; k < 16; k++) exp_w[k] = tile[(k / 4) * 16 + (k % 4) * 2];
    end else if (words * 4 <= 128) begin
      exp_mode = 3; exp_n = words;
      for (int j = 0; j < 2560; j++) sb[j] = 1'b0;
      sp = 0;
      put_bits(tile[0], 32);
      for (int ch = 0; ch < 4; ch++) put_bits(32'(wm[ch]), 4);
      for (int i = 1; i < 64; i++) begin
        int nb;
        nb = (i % 8 == 0) ? i - 8 : i - 1;
        for (int ch = 0; ch < 4; ch++) begin
          logic [7:0] df;
          df = tile[i][8*ch +: 8] - tile[nb][8*ch +: 8];
          put_bits({24'b0, df}, wm[ch]);
        end
      end
      for (int k = 0; k < words; k++)
        for (int j = 0; j < 32; j++) exp_w[k][j] = sb[32 * k + j];
    end else begin
      exp_mode = 0; exp_n = 64;
      for (int k = 0; k < 64; k++) exp_w[k] = tile[k];
    end
    exp_bytes = exp_n * 4;
  endtask

  task automatic send_tile();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = tile[i];
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input bit stall);
    int guard;
    bit prev_stall, done, first;
    logic [31:0] prev_d;
    int m0, b0;
    got_n = 0; hold_err = 0; rdy_err = 0; const_err = 0;
    guard = 0; prev_stall = 0; done = 0; first = 1; prev_d = '0;
    m0 = 0; b0 = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
      out_ready = stall ? (guard % 3 == 0) : 1'b1;
      if (prev_stall && (!out_valid || out_data != prev_d)) hold_err = 1;
      if (out_valid && in_ready) rdy_err = 1;
      if (out_valid) begin
        if (first) begin m0 = out_mode; b0 = out_bytes; first = 0; end
        else if (out_mode != m0 || out_bytes != b0) const_err = 1;
        got_mode = out_mode; got_bytes = out_bytes;
        if (out_ready) begin
          got_w[got_n] = out_data;
          got_n++;
          if (out_last) done = 1;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(done, "R10", "final word flagged", done, 1);
  endtask

  task automatic run_case(input string req, input bit stall);
    bit ok;
    int bad;
    model();
    send_tile();
    collect(stall);
    chk(got_mode == exp_mode, "R9", {req, " tag"}, got_mode, exp_mode);
    chk(got_bytes == exp_bytes, req, "byte length", got_bytes, exp_bytes);
    chk(got_n == exp_n, "R10", {req, " word count"}, got_n, exp_n);
    ok = 1; bad = 0;
    for (int k = 0; k < exp_n && k < got_n; k++)
      if (ok && got_w[k] !== exp_w[k]) begin ok = 0; bad = k; end
    chk(ok, req, $sformatf("payload word %0d", bad), got_w[bad], exp_w[bad]);
    chk(!rdy_err, "R1", "in_ready low during output", rdy_err, 0);
    chk(!const_err, "R10", "tag/length steady", const_err, 0);
    chk(in_ready == 1'b1, "R1", "ready after last word", in_ready, 1);
    if (stall) chk(!hold_err, "R10", "word held while stalled", hold_err, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "reset out_valid", out_valid, 0);
  endtask

  task automatic t_const42();
    for (int i = 0; i < 64; i++)
      tile[i] = 32'hA000_0000 + 32'((i / 16) * 16 + ((i % 8) / 4));
    run_case("R2", 0);
    chk(got_mode == 1 && got_bytes == 32, "R2", "4x2 tag/len", got_mode, 1);
  endtask

  task automatic t_const22();
    for (int i = 0; i < 64; i++)
      tile[i] = 32'h1234_0000 + 32'((i / 16) * 16 + ((i % 8) / 2));
    run_case("R3", 0);
    chk(got_mode == 2 && got_bytes == 64, "R3", "2x2 tag/len", got_mode, 2);
  endtask

  task automatic gradient();
    for (int i = 0; i < 64; i++) begin
      int r, c;
      r = i / 8; c = i % 8;
      tile[i] = {8'hFF, 8'(r * 3), 8'(c * 2), 8'(r * 8 + c)};
    end
  endtask

  task automatic t_gradient();
    gradient();
    run_case("R6", 0);
    chk(got_w[0] == tile[0], "R4", "word 0 is pixel 0", got_w[0], tile[0]);
    chk(got_w[1][15:0] == 16'h0335, "R5", "width header", got_w[1][15:0], 16'h0335);
    chk(exp_hdr == 16'h0335, "R5", "model header", exp_hdr, 16'h0335);
    chk(got_mode == 3 && got_bytes == 96, "R7", "delta length", got_bytes, 96);
  endtask

  task automatic alternating(input bit over);
    for (int i = 0; i < 64; i++) begin
      int c;
      bit odd;
      c = i % 8; odd = c[0];
      tile[i] = {over ? 8'(c) : 8'(255 - c), odd ? 8'd1 : 8'd0,
                 odd ? 8'd5 : 8'd0, odd ? 8'd100 : 8'd0};
    end
  endtask

  task automatic t_limit_fit();
    alternating(0);
    run_case("R7", 0);
    chk(got_mode == 3 && got_bytes == 128, "R7", "fits at 128 bytes", got_bytes, 128);
    chk(got_w[1][15:0] == 16'h1248, "R5", "signed widths", got_w[1][15:0], 16'h1248);
  endtask

  task automatic t_limit_over();
    alternating(1);
    run_case("R8", 0);
    chk(got_mode == 0 && got_bytes == 256, "R7", "over limit goes raw", got_mode, 0);
  endtask

  task automatic t_noise();
    logic [31:0] x;
    x = 32'h1357_9BDF;
    for (int i = 0; i < 64; i++) begin
      x = x * 32'd1664525 + 32'd1013904223;
      tile[i] = x;
    end
    run_case("R8", 0);
    chk(got_mode == 0, "R8", "noise is raw", got_mode, 0);
  endtask

  task automatic t_stall();
    gradient();
    run_case("R10", 1);
    for (int i = 0; i < 64; i++) tile[i] = 32'hC0DE_0000 + 32'((i / 16) * 2 + ((i % 8) / 4));
    run_case("R2", 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_const42();
    t_const22();
    t_gradient();
    t_limit_fit();
    t_limit_over();
    t_noise();
    t_const42();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule